// File: doc/BRIEF.md
# Time-Slot Assigned PCM Serial Port

This block connects a parallel 8-bit sample interface to a time-division multiplexed serial PCM bus. All of its logic runs from the serial bit clock. Transmit and receive each have their own frame sync, frame counter, programmed slot number and programmed lane, chosen from two lanes per direction. A frame holds up to `SLOTS` slots of eight bits. The first bit of slot 0 starts in the bit period after the one in which the sync was high.

On the transmit side, the port loads the outgoing byte at the start of its slot and shifts it out MSB first on rising edges. It enables only the selected lane, for exactly eight bit periods. An active-low slot window output goes low for the same eight periods. On the receive side, the port samples the selected lane on falling edges during its slot and presents the finished byte with a one-period valid strobe.

A law selection sets the inversion mask used on both directions. A digital loopback mode sends the last received line byte back out in the transmit slot. The companding arithmetic and all analog functions belong to the surrounding logic.

Top module: `pcm_tdm_port`

## Requirements
- R1: While reset is asserted and after it is released, with no sync seen: `tx_oe` is all zero, `tsx_n` is 1, `tx_load` and `rx_valid` are 0, and `rx_pcm` shows a stored byte of 0 through the mask.
- R2: A rising bit-clock edge that samples a frame sync high starts the frame. The following bit period is bit 0 of slot 0, and slot s bit b occupies the period that begins 8*s+b edges after that edge.
- R3: During the eight periods of the transmit slot, only `tx_oe[tx_lane]` is 1 and all other lane enables are 0. `tx_bit` carries the byte MSB first, one bit per period, changing on rising edges. Outside the slot, every lane enable is 0.
- R4: `tsx_n` is 0 exactly during the eight transmit slot periods and 1 otherwise.
- R5: `tx_load` is 1 for one period per frame, the first period of the transmit slot. The byte sent is the value on `tx_pcm` at the edge that starts that period.
- R6: Receive bits are sampled from `dr[rx_lane]` on falling edges during the receive slot only, MSB first. The other lane and all other slots have no effect on the received byte.
- R7: `rx_valid` is 1 for one period, the period right after the last receive bit. `rx_pcm` keeps the new byte until the next receive slot completes.
- R8: `law_sel` codes: 0 = mu-law (mask 0x00), 1 = A-law (mask 0x55, even bits 0,2,4,6 inverted), 2 = A-law without inversion (mask 0x00), 3 = treated like 0. The mask is XORed into the transmitted byte and into `rx_pcm`, and `rx_pcm` follows a change of `law_sel` at once.
- R9: With `loopback` = 1, the transmit slot sends the last received raw line byte with no mask applied, instead of `tx_pcm`.
- R10: A slot number of `SLOTS` or more never becomes active. It produces no lane enable, no `tx_load` and no `rx_valid`, and the stored receive byte is unchanged.
- R11: A new sync restarts the counting even in the middle of a frame. After the last bit of slot `SLOTS-1`, nothing becomes active until the next sync.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| bclk | input | 1 | Serial bit clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| fs_tx | input | 1 | Transmit frame sync, one bit period wide |
| fs_rx | input | 1 | Receive frame sync, one bit period wide |
| tx_slot | input | SW+1 | Transmit slot number |
| tx_lane | input | LW | Transmit lane select |
| rx_slot | input | SW+1 | Receive slot number |
| rx_lane | input | LW | Receive lane select |
| law_sel | input | 2 | Companding law code (R8) |
| loopback | input | 1 | Digital loopback enable |
| tx_pcm | input | 8 | Parallel byte to transmit |
| dr | input | NLANE | Serial receive lanes |
| tx_bit | output | 1 | Serial transmit data, shared by the lanes |
| tx_oe | output | NLANE | Per-lane output enable for `tx_bit` |
| tsx_n | output | 1 | Transmit slot window, active low |
| tx_load | output | 1 | Strobe: `tx_pcm` taken for this slot |
| rx_pcm | output | 8 | Last received byte after the mask |
| rx_valid | output | 1 | Strobe: new byte on `rx_pcm` |

## Verification
The hardest situations to reach are the ones where wrong timing would still give plausible bytes. One is a sync arriving again partway through a frame. The other is a counter that wraps past the last slot instead of stopping. The bench reaches the first by sending a sync, letting twelve bit periods pass, and syncing again before the transmit slot. It reaches the second by running more than a full frame with no sync while slot 0 is programmed. The bench also drives the complement of the receive byte on the unselected lane and a changing pattern outside the slot, so that a port reading the wrong lane or the wrong slot produces a different byte.

// File: rtl/pcm_port_pkg.sv
package pcm_port_pkg;

    localparam int SAMPLE_W = 8;
    localparam int BIT_W    = $clog2(SAMPLE_W);

    typedef enum logic [1:0] {
        LAW_MU     = 2'd0,
        LAW_A      = 2'd1,
        LAW_A_FLAT = 2'd2,
        LAW_SPARE  = 2'd3
    } law_e;

    // Inversion applied on the line side: alternate bits for A-law only.
    function automatic logic [SAMPLE_W-1:0] inv_mask(input law_e law);
        logic [SAMPLE_W-1:0] m;
        m = '0;
        if (law == LAW_A) begin
            for (int i = 0; i < SAMPLE_W; i += 2) m[i] = 1'b1;
        end
        return m;
    endfunction

endpackage

// File: rtl/pcm_frame_counter.sv
module pcm_frame_counter
    import pcm_port_pkg::*;
#(
    parameter int SLOTS = 64,
    parameter int SW    = $clog2(SLOTS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sync,
    output logic             cur_valid,
    output logic [SW-1:0]    cur_slot,
    output logic [BIT_W-1:0] cur_bit,
    output logic             nxt_valid,
    output logic [SW-1:0]    nxt_slot,
    output logic [BIT_W-1:0] nxt_bit
);

    localparam logic [SW-1:0]    LAST_SLOT = SW'(SLOTS - 1);
    localparam logic [BIT_W-1:0] LAST_BIT  = BIT_W'(SAMPLE_W - 1);

    typedef struct packed {
        logic             valid;
        logic [SW-1:0]    slot;
        logic [BIT_W-1:0] bitn;
    } pos_t;

    pos_t pos_d, pos_q;

    always_comb begin
        pos_d = pos_q;
        if (sync) begin
            pos_d.valid = 1'b1;
            pos_d.slot  = '0;
            pos_d.bitn  = '0;
        end else if (pos_q.valid) begin
            if (pos_q.bitn == LAST_BIT) begin
                pos_d.bitn = '0;
                if (pos_q.slot == LAST_SLOT) pos_d.valid = 1'b0;
                else                         pos_d.slot  = pos_q.slot + 1'b1;
            end else begin
                pos_d.bitn = pos_q.bitn + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pos_q <= '0;
        else        pos_q <= pos_d;
    end

    assign cur_valid = pos_q.valid;
    assign cur_slot  = pos_q.slot;
    assign cur_bit   = pos_q.bitn;
    assign nxt_valid = pos_d.valid;
    assign nxt_slot  = pos_d.slot;
    assign nxt_bit   = pos_d.bitn;

    // R2: a sampled sync puts the next period at slot 0, bit 0
    p_sync_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
        sync |=> (cur_valid && cur_slot == '0 && cur_bit == '0));

    // R2: inside a slot the bit index advances by one per period
    p_bit_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_valid && cur_bit != LAST_BIT && !sync)
        |=> (cur_valid && cur_bit == BIT_W'($past(cur_bit) + 1'b1)));

    // R11: the frame closes after the last bit of the last slot
    p_frame_end_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_valid && cur_slot == LAST_SLOT && cur_bit == LAST_BIT && !sync)
        |=> !cur_valid);

endmodule

// File: rtl/pcm_rx_capture.sv
module pcm_rx_capture
    import pcm_port_pkg::*;
#(
    parameter int NLANE = 2,
    parameter int LW    = 1,
    parameter int SW    = 6
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                win_valid,
    input  logic [SW-1:0]       win_slot,
    input  logic [BIT_W-1:0]    win_bit,
    input  logic [SW:0]         rx_slot,
    input  logic [LW-1:0]       rx_lane,
    input  logic [NLANE-1:0]    dr,
    output logic [SAMPLE_W-1:0] shift_word,
    output logic                done
);

    localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(SAMPLE_W - 1);

    typedef struct packed {
        logic [SAMPLE_W-1:0] sh;
        logic                fin;
    } cap_t;

    cap_t cap_d, cap_q;
    logic hit;

    assign hit = win_valid && ({1'b0, win_slot} == rx_slot);

    always_comb begin
        cap_d     = cap_q;
        cap_d.fin = 1'b0;
        if (hit) begin
            cap_d.sh  = {cap_q.sh[SAMPLE_W-2:0], dr[rx_lane]};
            cap_d.fin = (win_bit == LAST_BIT);
        end
    end

    // Sampling edge is the falling edge, mid bit period
    always_ff @(negedge clk or negedge rst_n) begin
        if (!rst_n) cap_q <= '0;
        else        cap_q <= cap_d;
    end

    assign shift_word = cap_q.sh;
    assign done       = cap_q.fin;

    // R6: outside the receive window the shift register does not move
    p_ignore_outside_r6: assert property (@(negedge clk) disable iff (!rst_n)
        !hit |=> $stable(shift_word));

    // R7: the completion flag lasts a single falling-edge interval
    p_done_single_r7: assert property (@(negedge clk) disable iff (!rst_n)
        done |=> !done);

endmodule

// File: rtl/pcm_tdm_port.sv
module pcm_tdm_port
    import pcm_port_pkg::*;
#(
    parameter  int SLOTS = 64,
    parameter  int NLANE = 2,
    localparam int SW    = $clog2(SLOTS),
    localparam int LW    = (NLANE > 1) ? $clog2(NLANE) : 1
) (
    input  logic                bclk,
    input  logic                rst_n,
    input  logic                fs_tx,
    input  logic                fs_rx,
    input  logic [SW:0]         tx_slot,
    input  logic [LW-1:0]       tx_lane,
    input  logic [SW:0]         rx_slot,
    input  logic [LW-1:0]       rx_lane,
    input  logic [1:0]          law_sel,
    input  logic                loopback,
    input  logic [SAMPLE_W-1:0] tx_pcm,
    input  logic [NLANE-1:0]    dr,
    output logic                tx_bit,
    output logic [NLANE-1:0]    tx_oe,
    output logic                tsx_n,
    output logic                tx_load,
    output logic [SAMPLE_W-1:0] rx_pcm,
    output logic                rx_valid
);

    typedef struct packed {
        logic [SAMPLE_W-1:0] sr;
        logic [NLANE-1:0]    oe;
        logic                tsx_n;
        logic                load;
        logic [SAMPLE_W-1:0] hold;
        logic                rxv;
    } port_t;

    localparam port_t PORT_RST = '{sr: '0, oe: '0, tsx_n: 1'b1, load: 1'b0,
                                   hold: '0, rxv: 1'b0};

    port_t st_d, st_q;

    logic                tx_cur_valid, tx_nxt_valid;
    logic [SW-1:0]       tx_cur_slot, tx_nxt_slot;
    logic [BIT_W-1:0]    tx_cur_bit, tx_nxt_bit;
    logic                rx_cur_valid, rx_nxt_valid;
    logic [SW-1:0]       rx_cur_slot, rx_nxt_slot;
    logic [BIT_W-1:0]    rx_cur_bit, rx_nxt_bit;
    logic [SAMPLE_W-1:0] rx_word;
    logic                rx_done;
    logic [SAMPLE_W-1:0] mask;
    logic                tx_hit;

    pcm_frame_counter #(.SLOTS(SLOTS), .SW(SW)) u_tx_cnt (
        .clk       (bclk),
        .rst_n     (rst_n),
        .sync      (fs_tx),
        .cur_valid (tx_cur_valid),
        .cur_slot  (tx_cur_slot),
        .cur_bit   (tx_cur_bit),
        .nxt_valid (tx_nxt_valid),
        .nxt_slot  (tx_nxt_slot),
        .nxt_bit   (tx_nxt_bit)
    );

    pcm_frame_counter #(.SLOTS(SLOTS), .SW(SW)) u_rx_cnt (
        .clk       (bclk),
        .rst_n     (rst_n),
        .sync      (fs_rx),
        .cur_valid (rx_cur_valid),
        .cur_slot  (rx_cur_slot),
        .cur_bit   (rx_cur_bit),
        .nxt_valid (rx_nxt_valid),
        .nxt_slot  (rx_nxt_slot),
        .nxt_bit   (rx_nxt_bit)
    );

    pcm_rx_capture #(.NLANE(NLANE), .LW(LW), .SW(SW)) u_rx_cap (
        .clk        (bclk),
        .rst_n      (rst_n),
        .win_valid  (rx_cur_valid),
        .win_slot   (rx_cur_slot),
        .win_bit    (rx_cur_bit),
        .rx_slot    (rx_slot),
        .rx_lane    (rx_lane),
        .dr         (dr),
        .shift_word (rx_word),
        .done       (rx_done)
    );

    assign mask   = inv_mask(law_e'(law_sel));
    assign tx_hit = tx_nxt_valid && ({1'b0, tx_nxt_slot} == tx_slot);

    always_comb begin
        st_d      = st_q;
        st_d.load = 1'b0;
        st_d.rxv  = 1'b0;
        if (tx_hit) begin
            if (tx_nxt_bit == '0) begin
                st_d.sr   = loopback ? st_q.hold : (tx_pcm ^ mask);
                st_d.load = 1'b1;
            end else begin
                st_d.sr = {st_q.sr[SAMPLE_W-2:0], 1'b0};
            end
        end
        for (int i = 0; i < NLANE; i++) begin
            st_d.oe[i] = tx_hit && (tx_lane == LW'(i));
        end
        st_d.tsx_n = !tx_hit;
        if (rx_done) begin
            st_d.hold = rx_word;
            st_d.rxv  = 1'b1;
        end
    end

    always_ff @(posedge bclk or negedge rst_n) begin
        if (!rst_n) st_q <= PORT_RST;
        else        st_q <= st_d;
    end

    assign tx_bit   = st_q.sr[SAMPLE_W-1] & (|st_q.oe);
    assign tx_oe    = st_q.oe;
    assign tsx_n    = st_q.tsx_n;
    assign tx_load  = st_q.load;
    assign rx_pcm   = st_q.hold ^ mask;
    assign rx_valid = st_q.rxv;

    // R3: never more than one lane driven
    p_oe_single_r3: assert property (@(posedge bclk) disable iff (!rst_n)
        $onehot0(tx_oe));

    // R3: a driven lane lies inside the programmed slot of a live frame
    p_tx_window_r3: assert property (@(posedge bclk) disable iff (!rst_n)
        (|tx_oe) |-> (tx_cur_valid && {1'b0, tx_cur_slot} == tx_slot));

    // R5: the slot window opens together with the load strobe, on bit 0
    p_load_first_r5: assert property (@(posedge bclk) disable iff (!rst_n)
        $fell(tsx_n) |-> tx_load);

    p_load_bit0_r5: assert property (@(posedge bclk) disable iff (!rst_n)
        tx_load |-> (tx_cur_bit == '0));

    // R7: receive strobe is one period wide
    p_rxv_single_r7: assert property (@(posedge bclk) disable iff (!rst_n)
        rx_valid |=> !rx_valid);

    // R11: the look-ahead position keeps its slot until the next slot boundary
    p_rx_slot_hold_r11: assert property (@(posedge bclk) disable iff (!rst_n)
        (rx_cur_valid && rx_nxt_valid && rx_nxt_bit != '0) |-> (rx_nxt_slot == rx_cur_slot));

endmodule

// File: tb/tb_pcm_tdm_port.sv
module tb_pcm_tdm_port;

    localparam int TCK   = 10;
    localparam int SLOTS = 64;
    localparam int NLANE = 2;
    localparam int SW    = 6;
    localparam int LW    = 1;

    logic             bclk = 1'b0;
    logic             rst_n;
    logic             fs_tx, fs_rx;
    logic [SW:0]      tx_slot, rx_slot;
    logic [LW-1:0]    tx_lane, rx_lane;
    logic [1:0]       law_sel;
    logic             loopback;
    logic [7:0]       tx_pcm;
    logic [NLANE-1:0] dr;
    logic             tx_bit;
    logic [NLANE-1:0] tx_oe;
    logic             tsx_n, tx_load, rx_valid;
    logic [7:0]       rx_pcm;

    int n_chk = 0;
    int n_bad = 0;

    pcm_tdm_port #(.SLOTS(SLOTS), .NLANE(NLANE)) dut (
        .bclk(bclk), .rst_n(rst_n), .fs_tx(fs_tx), .fs_rx(fs_rx),
        .tx_slot(tx_slot), .tx_lane(tx_lane), .rx_slot(rx_slot), .rx_lane(rx_lane),
        .law_sel(law_sel), .loopback(loopback), .tx_pcm(tx_pcm), .dr(dr),
        .tx_bit(tx_bit), .tx_oe(tx_oe), .tsx_n(tsx_n), .tx_load(tx_load),
        .rx_pcm(rx_pcm), .rx_valid(rx_valid)
    );

    always #(TCK/2) bclk = ~bclk;

    typedef struct packed {
        logic [6:0] ts;
        logic       tl;
        logic [6:0] rs;
        logic       rl;
        logic [1:0] law;
        logic       lp;
        logic [7:0] txb;
        logic [7:0] rxb;
        logic [7:0] etx;
        logic [7:0] erx;
    } vec_t;

    // slot/lane/law/loop stimulus with hand-derived expected line and parallel bytes
    localparam vec_t VEC [6] = '{
        '{7'd0,  1'b0, 7'd0,  1'b0, 2'd0, 1'b0, 8'hA5, 8'h3C, 8'hA5, 8'h3C},
        '{7'd5,  1'b1, 7'd2,  1'b1, 2'd1, 1'b0, 8'h0F, 8'hC3, 8'h5A, 8'h96},
        '{7'd3,  1'b0, 7'd7,  1'b0, 2'd2, 1'b0, 8'h81, 8'h7E, 8'h81, 8'h7E},
        '{7'd4,  1'b1, 7'd1,  1'b0, 2'd1, 1'b1, 8'hFF, 8'h96, 8'h96, 8'hC3},
        '{7'd63, 1'b0, 7'd63, 1'b1, 2'd0, 1'b0, 8'h12, 8'h34, 8'h12, 8'h34},
        '{7'd64, 1'b0, 7'd64, 1'b0, 2'd0, 1'b0, 8'h77, 8'h99, 8'h00, 8'h34}
    };

    task automatic chk(input logic ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic run_frame(input vec_t v, output logic [7:0] got_tx, output int loads,
                             output int rxv, output logic [7:0] got_rx, output int win_err);
        int   np;
        int   mx;
        logic live_tx;
        logic live_rx;
        live_tx = (v.ts < SLOTS);
        live_rx = (v.rs < SLOTS);
        mx = (v.ts > v.rs) ? int'(v.ts) : int'(v.rs);
        np = 8 * (mx + 2);
        if (np > 8 * SLOTS + 8) np = 8 * SLOTS + 8;
        got_tx = 8'h00; got_rx = 8'h00; loads = 0; rxv = 0; win_err = 0;
        @(posedge bclk); #1;
        tx_slot = v.ts; tx_lane = v.tl; rx_slot = v.rs; rx_lane = v.rl;
        law_sel = v.law; loopback = v.lp; tx_pcm = v.txb;
        fs_tx = 1'b1; fs_rx = 1'b1;
        @(posedge bclk); #1;
        fs_tx = 1'b0; fs_rx = 1'b0;
        for (int p = 0; p < np; p++) begin
            int s;
            int b;
            logic in_tx;
            logic [NLANE-1:0] exp_oe;
            s = p / 8;
            b = p % 8;
            if (live_rx && s == int'(v.rs)) begin
                dr[v.rl]  = v.rxb[7-b];
                dr[~v.rl] = ~v.rxb[7-b];
            end else begin
                dr = p[1:0];
            end
            @(negedge bclk);
            in_tx  = live_tx && (s == int'(v.ts));
            exp_oe = in_tx ? (2'b01 << v.tl) : 2'b00;
            if (tx_oe !== exp_oe || tsx_n !== !in_tx) win_err++;
            if (in_tx) got_tx[7-b] = tx_bit;
            if (tx_load) begin
                loads++;
                if (!(in_tx && b == 0)) win_err++;
            end
            if (rx_valid) begin
                rxv++;
                got_rx = rx_pcm;
                if (!live_rx || p != 8 * int'(v.rs) + 8) win_err++;
            end
            @(posedge bclk); #1;
        end
    endtask

    initial begin
        #(TCK * 200000);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: run did not complete actual=hung expected=done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        logic [7:0] gtx;
        logic [7:0] grx;
        int ld;
        int rv;
        int we;
        int stray;
        rst_n = 1'b0; fs_tx = 1'b0; fs_rx = 1'b0;
        tx_slot = '0; rx_slot = '0; tx_lane = '0; rx_lane = '0;
        law_sel = 2'd0; loopback = 1'b0; tx_pcm = 8'h00; dr = '0;

        // R1: reset state, during and after reset
        repeat (3) @(posedge bclk);
        @(negedge bclk);
        chk(tx_oe == 2'b00 && tsx_n == 1'b1, "R1 window idle in reset",
            {tx_oe, tsx_n}, 32'h1);
        chk(tx_load == 1'b0 && rx_valid == 1'b0 && rx_pcm == 8'h00, "R1 strobes/byte in reset",
            {tx_load, rx_valid, rx_pcm}, 32'h0);
        @(posedge bclk); #1;
        rst_n = 1'b1;
        repeat (4) @(posedge bclk);
        @(negedge bclk);
        chk(tx_oe == 2'b00 && tsx_n == 1'b1 && tx_load == 1'b0 && rx_valid == 1'b0,
            "R1 idle before sync", {tx_oe, tsx_n, tx_load, rx_valid}, 32'h4);

        // Vector table: R2 R3 R4 R5 R6 R7 R8 R9 R10
        foreach (VEC[i]) begin
            logic live_t;
            logic live_r;
            live_t = (VEC[i].ts < SLOTS);
            live_r = (VEC[i].rs < SLOTS);
            run_frame(VEC[i], gtx, ld, rv, grx, we);
            chk(we == 0, $sformatf("R2/R3/R4 timing of vector %0d", i), we, 0);
            chk(ld == (live_t ? 1 : 0), $sformatf("R5/R10 load count vector %0d", i),
                ld, live_t ? 1 : 0);
            chk(rv == (live_r ? 1 : 0), $sformatf("R7/R10 rx_valid count vector %0d", i),
                rv, live_r ? 1 : 0);
            if (live_t)
                chk(gtx == VEC[i].etx, $sformatf("R3/R8/R9 tx byte vector %0d", i),
                    gtx, VEC[i].etx);
            if (live_r)
                chk(grx == VEC[i].erx, $sformatf("R6/R8 rx byte vector %0d", i),
                    grx, VEC[i].erx);
        end

        // R7 / R10: inactive receive slot leaves the stored byte in place
        @(negedge bclk);
        chk(rx_pcm == 8'h34, "R7 rx byte held across inactive frame", rx_pcm, 8'h34);

        // R8: law change re-masks the stored byte immediately
        law_sel = 2'd1;
        #1;
        chk(rx_pcm == 8'h61, "R8 A-law mask on stored byte", rx_pcm, 8'h61);
        law_sel = 2'd3;
        #1;
        chk(rx_pcm == 8'h34, "R8 spare code acts as no inversion", rx_pcm, 8'h34);

        // R11: sync arriving mid-frame restarts the count
        @(posedge bclk); #1;
        tx_slot = 7'd2; tx_lane = 1'b0; rx_slot = 7'd64; law_sel = 2'd0;
        loopback = 1'b0; fs_tx = 1'b1; fs_rx = 1'b1;
        @(posedge bclk); #1;
        fs_tx = 1'b0; fs_rx = 1'b0;
        repeat (11) @(posedge bclk);
        run_frame('{7'd2, 1'b0, 7'd64, 1'b0, 2'd0, 1'b0, 8'h5A, 8'h00, 8'h5A, 8'h00},
                  gtx, ld, rv, grx, we);
        chk(we == 0 && ld == 1, "R11 resync window timing", we, 0);
        chk(gtx == 8'h5A, "R11 resync tx byte", gtx, 8'h5A);

        // R11: no wrap after the last slot without a new sync
        run_frame('{7'd0, 1'b1, 7'd64, 1'b0, 2'd0, 1'b0, 8'hC6, 8'h00, 8'hC6, 8'h00},
                  gtx, ld, rv, grx, we);
        chk(we == 0 && gtx == 8'hC6, "R11 slot 0 on lane 1", gtx, 8'hC6);
        stray = 0;
        for (int k = 0; k < 8 * SLOTS + 64; k++) begin
            dr = k[1:0];
            @(negedge bclk);
            if (tx_oe != 2'b00 || tsx_n != 1'b1 || tx_load || rx_valid) stray++;
            @(posedge bclk); #1;
        end
        chk(stray == 0, "R11 quiet after frame end", stray, 0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule